// File: doc/BRIEF.md
# Strided Vector Load Address Generator

This block turns one vector load into a stream of per-element memory requests. Each request carries a byte address and the index of the destination register that the element lands in. A load names a base register, the base address held in that register, a signed immediate, a first destination register and an element count. The block accepts the load, works out a start address and an element step, and then issues one request per element on a valid/ready interface. It raises a one-cycle completion pulse when the last request has been taken.

Two programmable offset slots decide how the immediate is used. A slot is written by a set-offset operation. The operation records a register number, a bank (integer or floating point), a stride-mode bit and a full-width offset amount. At load time the block compares the slots against the base register and its bank.

- On a match in stride-immediate mode, the immediate becomes the distance between consecutive elements, and the slot's amount is added once to the base.
- On a match in unit mode, elements are packed at the element size, with the slot's amount as the displacement.
- Without a match, the load behaves as a contiguous load whose displacement is the immediate.

Memory timing, returned data and register writeback are handled elsewhere.

Top module: `strided_load_agen`

## Requirements
- R1: After reset, `req_valid` and `ld_done` are 0, `ld_ready` is 1, and both slots are empty, so no load matches a slot until that slot is written.
- R2: When `cfg_we` is 1 at a clock edge, the slot selected by `cfg_slot` takes `cfg_reg`, `cfg_bank` (0 = integer, 1 = float), `cfg_stride_imm` (1 = immediate is the stride, 0 = unit) and `cfg_amount`. The write affects loads accepted at later edges.
- R3: A slot matches a load only if it has been written, its register equals `ld_base_reg` and its bank equals `ld_base_bank`. When both slots match, slot 0 is used.
- R4: With a matching slot in stride-immediate mode, element i has address `ld_base_addr + amount + sext(ld_imm)*i`, taken modulo 2^XLEN.
- R5: With a matching slot in unit mode, element i has address `ld_base_addr + amount + ELEM_BYTES*i`, where ELEM_BYTES is 4 by default.
- R6: Without a matching slot, element i has address `ld_base_addr + sext(ld_imm) + ELEM_BYTES*i`.
- R7: The `req_dest` of element i is `ld_dest_reg + i`, taken modulo 2^RIDX_W, so it wraps from 31 to 0.
- R8: Exactly `ld_vlen` requests are issued, in element order, and one element advances per valid&ready handshake. While a request is stalled, `req_valid`, `req_addr`, `req_dest` and `req_last` hold. `req_last` is 1 only on element `ld_vlen-1`.
- R9: In the cycle after the final handshake, `ld_done` is 1 for one cycle, `req_valid` is 0 and `ld_ready` is 1.
- R10: A load with `ld_vlen` = 0 issues no request, and `ld_done` is 1 in the cycle after it is accepted.
- R11: `ld_ready` is 1 only while no burst is in progress, and `req_valid` is 0 whenever `ld_ready` is 1. Slot writes made during a burst do not change that burst's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Set-offset write strobe |
| cfg_slot | input | 1 | Slot selected by the write |
| cfg_reg | input | RIDX_W | Register number stored in the slot |
| cfg_bank | input | 1 | Bank stored in the slot (0 int, 1 float) |
| cfg_stride_imm | input | 1 | 1 = immediate acts as stride, 0 = unit stride |
| cfg_amount | input | XLEN | Offset amount stored in the slot |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Block idle, load can be accepted |
| ld_base_reg | input | RIDX_W | Base register number of the load |
| ld_base_bank | input | 1 | Bank of the base register |
| ld_base_addr | input | XLEN | Value held in the base register |
| ld_imm | input | IMM_W | Signed load immediate |
| ld_dest_reg | input | RIDX_W | First destination register |
| ld_vlen | input | VLEN_W | Number of elements |
| req_valid | output | 1 | Element request valid |
| req_ready | input | 1 | Element request taken |
| req_addr | output | XLEN | Element byte address |
| req_dest | output | RIDX_W | Element destination register |
| req_last | output | 1 | Final element of the load |
| ld_done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 32-bit address, 5-bit register numbers, a 12-bit immediate and a 4-bit length. With a 4-bit length, every element count from 0 to 15 can be swept under all three addressing modes, with positive, negative and zero immediates and an irregular ready pattern. The short register field makes the destination wrap from 31 to 0 easy to reach. A full-width address makes the wrap past the top of memory reachable.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned AGEN_NSLOT = 2;

  localparam logic BANK_INT  = 1'b0;
  localparam logic BANK_FP   = 1'b1;
  localparam logic MODE_UNIT = 1'b0;
  localparam logic MODE_IMM  = 1'b1;

  typedef enum logic [0:0] {
    SQ_IDLE  = 1'b0,
    SQ_ISSUE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/agen_slot_bank.sv
module agen_slot_bank #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned NSLOT  = 2,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [RIDX_W-1:0] wr_reg,
  input  logic              wr_bank,
  input  logic              wr_mode,
  input  logic [XLEN-1:0]   wr_amount,
  input  logic [RIDX_W-1:0] lk_reg,
  input  logic              lk_bank,
  output logic              hit,
  output logic              hit_mode,
  output logic [XLEN-1:0]   hit_amount
);

  logic [NSLOT-1:0] match;
  logic [NSLOT-1:0] mode_v;
  logic [XLEN-1:0]  amt_v [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic              we_g;
    logic              vld_r;
    logic [RIDX_W-1:0] reg_r;
    logic              bank_r;
    logic              mode_r;
    logic [XLEN-1:0]   amt_r;

    assign we_g = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r  <= 1'b0;
        reg_r  <= '0;
        bank_r <= 1'b0;
        mode_r <= 1'b0;
        amt_r  <= '0;
      end else if (we_g) begin
        vld_r  <= 1'b1;
        reg_r  <= wr_reg;
        bank_r <= wr_bank;
        mode_r <= wr_mode;
        amt_r  <= wr_amount;
      end
    end

    assign match[g]  = vld_r && (reg_r == lk_reg) && (bank_r == lk_bank);
    assign mode_v[g] = mode_r;
    assign amt_v[g]  = amt_r;
  end

  // Lowest-numbered matching slot wins: scan downward so it is applied last.
  always_comb begin
    hit        = 1'b0;
    hit_mode   = 1'b0;
    hit_amount = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit        = 1'b1;
        hit_mode   = mode_v[i];
        hit_amount = amt_v[i];
      end
    end
  end

endmodule

// File: rtl/agen_plan.sv
module agen_plan
  import agen_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMM_W      = 12,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic             hit,
  input  logic             hit_mode,
  input  logic [XLEN-1:0]  hit_amount,
  input  logic [XLEN-1:0]  base_addr,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  start_addr,
  output logic [XLEN-1:0]  step
);

  localparam logic [XLEN-1:0] UNIT_STEP = XLEN'(ELEM_BYTES);

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] disp;

  assign imm_x = {{(XLEN - IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    if (hit && (hit_mode == MODE_IMM)) begin
      disp = hit_amount;
      step = imm_x;
    end else if (hit) begin
      disp = hit_amount;
      step = UNIT_STEP;
    end else begin
      disp = imm_x;
      step = UNIT_STEP;
    end
    start_addr = base_addr + disp;
  end

endmodule

// File: rtl/agen_seq.sv
module agen_seq
  import agen_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned VLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   start_addr,
  input  logic [XLEN-1:0]   step,
  input  logic [RIDX_W-1:0] dest,
  input  logic [VLEN_W-1:0] vlen,
  output logic              idle,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [XLEN-1:0]   req_addr,
  output logic [RIDX_W-1:0] req_dest,
  output logic              req_last,
  output logic              done
);

  localparam logic [VLEN_W-1:0] ONE = VLEN_W'(1);

  seq_state_e        state_q, state_d;
  logic [XLEN-1:0]   addr_q,  addr_d;
  logic [XLEN-1:0]   step_q,  step_d;
  logic [RIDX_W-1:0] dest_q,  dest_d;
  logic [VLEN_W-1:0] left_q,  left_d;
  logic              done_q,  done_d;
  logic              take;
  logic              data_en;

  assign take = (state_q == SQ_ISSUE) && req_ready;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    step_d  = step_q;
    dest_d  = dest_q;
    left_d  = left_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          addr_d = start_addr;
          step_d = step;
          dest_d = dest;
          left_d = vlen;
          if (vlen == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = SQ_ISSUE;
          end
        end
      end
      SQ_ISSUE: begin
        if (req_ready) begin
          addr_d = addr_q + step_q;
          dest_d = dest_q + RIDX_W'(1);
          left_d = left_q - ONE;
          if (left_q == ONE) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign data_en = ((state_q == SQ_IDLE) && start) || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
      dest_q <= '0;
      left_q <= '0;
    end else if (data_en) begin
      addr_q <= addr_d;
      step_q <= step_d;
      dest_q <= dest_d;
      left_q <= left_d;
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign req_valid = (state_q == SQ_ISSUE);
  assign req_addr  = addr_q;
  assign req_dest  = dest_q;
  assign req_last  = (state_q == SQ_ISSUE) && (left_q == ONE);
  assign done      = done_q;

endmodule

// File: rtl/strided_load_agen.sv
module strided_load_agen
  import agen_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RIDX_W     = 5,
  parameter int unsigned IMM_W      = 12,
  parameter int unsigned VLEN_W     = 4,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_slot,
  input  logic [RIDX_W-1:0] cfg_reg,
  input  logic              cfg_bank,
  input  logic              cfg_stride_imm,
  input  logic [XLEN-1:0]   cfg_amount,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [RIDX_W-1:0] ld_base_reg,
  input  logic              ld_base_bank,
  input  logic [XLEN-1:0]   ld_base_addr,
  input  logic [IMM_W-1:0]  ld_imm,
  input  logic [RIDX_W-1:0] ld_dest_reg,
  input  logic [VLEN_W-1:0] ld_vlen,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [XLEN-1:0]   req_addr,
  output logic [RIDX_W-1:0] req_dest,
  output logic              req_last,
  output logic              ld_done
);

  localparam int unsigned SEL_W = $clog2(AGEN_NSLOT);

  logic            lk_hit;
  logic            lk_mode;
  logic [XLEN-1:0] lk_amount;
  logic [XLEN-1:0] plan_addr;
  logic [XLEN-1:0] plan_step;
  logic            seq_idle;
  logic            accept;

  agen_slot_bank #(
    .XLEN  (XLEN),
    .RIDX_W(RIDX_W),
    .NSLOT (AGEN_NSLOT),
    .SEL_W (SEL_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (SEL_W'(cfg_slot)),
    .wr_reg    (cfg_reg),
    .wr_bank   (cfg_bank),
    .wr_mode   (cfg_stride_imm),
    .wr_amount (cfg_amount),
    .lk_reg    (ld_base_reg),
    .lk_bank   (ld_base_bank),
    .hit       (lk_hit),
    .hit_mode  (lk_mode),
    .hit_amount(lk_amount)
  );

  agen_plan #(
    .XLEN      (XLEN),
    .IMM_W     (IMM_W),
    .ELEM_BYTES(ELEM_BYTES)
  ) u_plan (
    .hit       (lk_hit),
    .hit_mode  (lk_mode),
    .hit_amount(lk_amount),
    .base_addr (ld_base_addr),
    .imm       (ld_imm),
    .start_addr(plan_addr),
    .step      (plan_step)
  );

  assign accept = ld_valid && seq_idle;

  agen_seq #(
    .XLEN  (XLEN),
    .RIDX_W(RIDX_W),
    .VLEN_W(VLEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_addr(plan_addr),
    .step      (plan_step),
    .dest      (ld_dest_reg),
    .vlen      (ld_vlen),
    .idle      (seq_idle),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_dest  (req_dest),
    .req_last  (req_last),
    .done      (ld_done)
  );

  assign ld_ready = seq_idle;

endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned VLEN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [VLEN_W-1:0] ld_vlen,
  input logic              req_valid,
  input logic              req_ready,
  input logic [XLEN-1:0]   req_addr,
  input logic [RIDX_W-1:0] req_dest,
  input logic              req_last,
  input logic              ld_done
);

  // R8: a stalled request keeps all of its fields
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_dest) && $stable(req_last)));

  // R7: a taken non-final element is followed by the next register index
  a_r7_dest_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=>
      (req_valid && (req_dest == $past(req_dest) + RIDX_W'(1))));

  // R9: completion follows the final handshake
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> (ld_done && ld_ready && !req_valid));

  // R10: an empty load completes without any request
  a_r10_empty_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && (ld_vlen == '0)) |=> (ld_done && !req_valid));

  // R11: idle and issuing never overlap
  a_r11_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !req_valid);

  // R8: a non-empty accepted load starts issuing next cycle
  a_r8_issue_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && (ld_vlen != '0)) |=> (req_valid && !ld_ready));

endmodule

bind strided_load_agen agen_chk #(
  .XLEN  (XLEN),
  .RIDX_W(RIDX_W),
  .VLEN_W(VLEN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_valid (ld_valid),
  .ld_ready (ld_ready),
  .ld_vlen  (ld_vlen),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_dest (req_dest),
  .req_last (req_last),
  .ld_done  (ld_done)
);

// File: tb/tb_strided_load_agen.sv
`timescale 1ns/1ps
module tb_strided_load_agen;
  localparam int XLEN = 32;
  localparam int RW   = 5;
  localparam int IW   = 12;
  localparam int VW   = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_slot, cfg_bank, cfg_stride_imm;
  logic [RW-1:0] cfg_reg;
  logic [31:0]   cfg_amount;
  logic          ld_valid, ld_ready, ld_base_bank;
  logic [RW-1:0] ld_base_reg, ld_dest_reg;
  logic [31:0]   ld_base_addr;
  logic [IW-1:0] ld_imm;
  logic [VW-1:0] ld_vlen;
  logic          req_valid, req_ready, req_last, ld_done;
  logic [31:0]   req_addr;
  logic [RW-1:0] req_dest;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strided_load_agen dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg), .cfg_bank(cfg_bank),
    .cfg_stride_imm(cfg_stride_imm), .cfg_amount(cfg_amount),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_base_reg(ld_base_reg),
    .ld_base_bank(ld_base_bank), .ld_base_addr(ld_base_addr), .ld_imm(ld_imm),
    .ld_dest_reg(ld_dest_reg), .ld_vlen(ld_vlen),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dest(req_dest), .req_last(req_last), .ld_done(ld_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] sx(input logic [IW-1:0] v);
    return {{(32-IW){v[IW-1]}}, v};
  endfunction

  task automatic write_slot(input logic s, input logic [RW-1:0] r, input logic b,
                            input logic m, input logic [31:0] a);
    @(negedge clk);
    cfg_we = 1; cfg_slot = s; cfg_reg = r; cfg_bank = b; cfg_stride_imm = m; cfg_amount = a;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Runs one load and checks every element against base + disp + step*i.
  task automatic run_load(input logic [RW-1:0] breg, input logic bbank,
                          input logic [RW-1:0] dreg, input logic [31:0] baddr,
                          input logic [IW-1:0] imm, input int n,
                          input logic [31:0] edisp, input logic [31:0] estep,
                          input string tag, input bit mid_cfg);
    int k = 0;
    int t = 0;
    @(negedge clk);
    chk(ld_ready == 1'b1, "R11", 32'(ld_ready), 32'd1);
    ld_valid = 1; ld_base_reg = breg; ld_base_bank = bbank; ld_dest_reg = dreg;
    ld_base_addr = baddr; ld_imm = imm; ld_vlen = VW'(n);
    @(negedge clk);
    ld_valid = 0;
    while (k < n) begin
      logic [31:0] ea;
      logic [RW-1:0] ed;
      logic rdy;
      rdy = (((cyc * 5) + 1) % 7) < 5;
      req_ready = rdy;
      if (mid_cfg && t == 0) begin
        cfg_we = 1; cfg_slot = 0; cfg_reg = breg; cfg_bank = bbank;
        cfg_stride_imm = 0; cfg_amount = 32'h100;
      end else begin
        cfg_we = 0;
      end
      ea = baddr + edisp + estep * 32'(k);
      ed = dreg + RW'(k);
      chk(req_valid == 1'b1, "R8", 32'(req_valid), 32'd1);
      chk(req_addr == ea, tag, req_addr, ea);
      chk(req_dest == ed, "R7", 32'(req_dest), 32'(ed));
      chk(req_last == (k == n - 1), "R8", 32'(req_last), 32'(k == n - 1));
      chk(ld_ready == 1'b0 && ld_done == 1'b0, "R11", {ld_ready, ld_done}, 32'd0);
      if (rdy) k++;
      t++;
      @(negedge clk);
    end
    cfg_we = 0;
    req_ready = 0;
    if (n == 0) chk(ld_done == 1'b1 && req_valid == 1'b0, "R10", {req_valid, ld_done}, 32'd1);
    else        chk(ld_done == 1'b1 && req_valid == 1'b0, "R9", {req_valid, ld_done}, 32'd1);
    chk(ld_ready == 1'b1, "R9", 32'(ld_ready), 32'd1);
    @(negedge clk);
    chk(ld_done == 1'b0, "R9", 32'(ld_done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] imms [3];
    imms[0] = 12'd12; imms[1] = 12'hFF8; imms[2] = 12'd0;
    rst_n = 0; cfg_we = 0; cfg_slot = 0; cfg_reg = 0; cfg_bank = 0; cfg_stride_imm = 0;
    cfg_amount = 0; ld_valid = 0; ld_base_reg = 0; ld_base_bank = 0; ld_base_addr = 0;
    ld_imm = 0; ld_dest_reg = 0; ld_vlen = 0; req_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_valid == 0 && ld_done == 0, "R1", {req_valid, ld_done}, 32'd0);
    chk(ld_ready == 1, "R1", 32'(ld_ready), 32'd1);
    // R1: empty slots, register 0 integer bank must not match
    run_load(5'd0, 1'b0, 5'd4, 32'h1000, 12'd12, 4, sx(12'd12), 32'd4, "R1", 0);

    // Configure: slot0 reg2 int immediate-stride amount 0; slot1 reg7 float unit amount 0x40
    write_slot(1'b0, 5'd2, 1'b0, 1'b1, 32'h0);
    write_slot(1'b1, 5'd7, 1'b1, 1'b0, 32'h40);

    // R4 example: immediate 12, four elements -> +0, +12, +24, +36
    run_load(5'd2, 1'b0, 5'd8, 32'h2000, 12'd12, 4, 32'd0, 32'd12, "R4", 0);

    for (int n = 0; n < 16; n++) begin
      for (int j = 0; j < 3; j++) begin
        run_load(5'd2, 1'b0, 5'(n), 32'h3000 + 32'(n * 64), imms[j], n,
                 32'd0, sx(imms[j]), "R4", 0);
        run_load(5'd7, 1'b1, 5'(n + 3), 32'h8000, imms[j], n,
                 32'h40, 32'd4, "R5", 0);
        // R3: bank mismatch on register 7 -> no match
        run_load(5'd7, 1'b0, 5'(n + 9), 32'h9000, imms[j], n,
                 sx(imms[j]), 32'd4, "R6", 0);
      end
    end

    // R7: destination wraps 30,31,0,1,2; R4 address wraps past the top
    run_load(5'd2, 1'b0, 5'd30, 32'hFFFF_FFF0, 12'd12, 5, 32'd0, 32'd12, "R7", 0);

    // R3: both slots match register 9 int; slot 0 must win
    write_slot(1'b0, 5'd9, 1'b0, 1'b1, 32'h10);
    write_slot(1'b1, 5'd9, 1'b0, 1'b0, 32'h20);
    run_load(5'd9, 1'b0, 5'd1, 32'h4000, 12'd24, 6, 32'h10, 32'd24, "R3", 0);
    // R2: rewrite slot 0 elsewhere; register 9 now falls to slot 1 (unit)
    write_slot(1'b0, 5'd10, 1'b0, 1'b1, 32'h0);
    run_load(5'd9, 1'b0, 5'd1, 32'h4000, 12'd24, 6, 32'h20, 32'd4, "R2", 0);

    // R11: slot 0 rewritten to unit mode during a stride-immediate burst
    run_load(5'd10, 1'b0, 5'd2, 32'h5000, 12'd16, 7, 32'd0, 32'd16, "R11", 1);
    // R2: the rewrite applies to the next load (unit, amount 0x100)
    run_load(5'd10, 1'b0, 5'd2, 32'h5000, 12'd16, 7, 32'h100, 32'd4, "R2", 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule